// File: doc/BRIEF.md
# Display RAM Auto-Increment Write Controller

This block keeps a bit-mapped display memory of 128 columns by 34 rows, together with the write pointer that addresses it. The rows are grouped into banks selected by a Y address, and the columns are selected by an X address. Banks 0 to 3 are full bytes. Bank 4 holds a single row, and bank 5 is a single-row icon bank. A host places the pointer with a set-address request, chooses vertical or horizontal stepping, and then streams data bytes through a valid/ready write port. Each accepted byte lands in the column and bank under the pointer. The bank decides which bits of the byte are kept. The pointer then steps according to the selected mode.

In horizontal mode the pointer walks along X and moves to the next bank at the end of a row. In vertical mode it walks down the banks and then moves to the next column. Both modes cover banks 0 to 4 only, and both restart at the origin after the last cell of bank 4. Once the pointer is placed in the icon bank it stays there and walks X only, whatever the mode. A registered read port returns any column byte, for checking or for display refresh.

Top module: `disp_ram_autoinc`

## Requirements
- R1: While `arst_n` is low, and after it is released, the pointer is at X=0, Y=0, horizontal mode is selected (`vert_mode`=0), and `rd_data` is 0.
- R2: A byte accepted at a pointer in banks 0 to 3 is stored whole. A read of that column and bank returns it on `rd_data` one clock after `rd_x`/`rd_y` are presented. A read and a write to the same cell at the same edge return the old contents.
- R3: In horizontal mode, outside bank 5, each accepted byte increments X. After X=NUM_COLS-1, X returns to 0 and Y increments.
- R4: In vertical mode, outside bank 5, each accepted byte increments Y. After Y=4, Y returns to 0 and X increments. After X=NUM_COLS-1, X returns to 0.
- R5: A byte accepted at X=NUM_COLS-1, Y=4 moves the pointer to X=0, Y=0 in either mode.
- R6: A byte written to bank 4 keeps only data bit 0. A read of bank 4 returns the stored bit at bit 0 and 0 in bits 7..1.
- R7: A byte written to bank 5 keeps only data bit 4. A read of bank 5 returns that bit at bit 4 and 0 elsewhere. In bank 5 each accepted byte increments X (NUM_COLS-1 wraps to 0), and Y stays 5 in both modes.
- R8: A set-address request with X>=NUM_COLS or Y>5 is ignored, and the pointer keeps its value.
- R9: A mode request (`mode_vert`: 1=vertical, 0=horizontal) does not move the pointer. It governs the next accepted byte.
- R10: `wr_ready` is low while `set_valid` is high. A byte offered in such a cycle is neither stored nor counted. The set-address request takes effect in that cycle.
- R11: A read with `rd_y` of 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| set_valid | input | 1 | Load the pointer from set_x/set_y |
| set_x | input | 8 | Requested column (one spare bit so out-of-range values can be sent) |
| set_y | input | 3 | Requested bank |
| mode_valid | input | 1 | Load the stepping mode |
| mode_vert | input | 1 | 1 = vertical, 0 = horizontal |
| wr_valid | input | 1 | Data byte offered |
| wr_data | input | 8 | Data byte |
| wr_ready | output | 1 | Byte accepted when high together with wr_valid |
| rd_x | input | 7 | Read column |
| rd_y | input | 3 | Read bank |
| rd_data | output | 8 | Registered read byte |
| ptr_x | output | 7 | Current pointer column |
| ptr_y | output | 3 | Current pointer bank |
| vert_mode | output | 1 | Current stepping mode |

## Verification
The bench builds the block with NUM_COLS=16 and keeps the bank layout at its default. With 16 columns, the end-of-row wrap, the full-memory wrap to the origin in both modes, and the X wrap inside the icon bank are all reached within a few dozen bytes. A 16-column memory also lets a final sweep read every written cell. The one spare bit on `set_x` makes the out-of-range column value 16 reachable for the rejection case.

// File: rtl/disp_ram_pkg.sv
package disp_ram_pkg;
  typedef enum logic {
    ADDR_HORIZ = 1'b0,
    ADDR_VERT  = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/disp_ptr_unit.sv
module disp_ptr_unit
  import disp_ram_pkg::*;
#(
  parameter int NUM_COLS   = 128,
  parameter int FULL_BANKS = 4,
  localparam int XW        = $clog2(NUM_COLS),
  localparam int YW        = $clog2(FULL_BANKS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_valid,
  input  logic [XW:0]   set_x,
  input  logic [YW-1:0] set_y,
  input  logic          adv,
  input  addr_mode_e    mode,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);
  localparam logic [XW-1:0] X_MAX  = XW'(NUM_COLS - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FULL_BANKS);
  localparam logic [YW-1:0] Y_ICON = YW'(FULL_BANKS + 1);

  logic [XW-1:0] x_nxt, x_inc;
  logic [YW-1:0] y_nxt;
  logic          x_last, set_ok, ld;

  assign x_last = (x == X_MAX);
  assign x_inc  = x_last ? '0 : x + 1'b1;
  assign set_ok = (set_x < (XW+1)'(NUM_COLS)) && (set_y <= Y_ICON);
  assign ld     = set_valid | adv;

  always_comb begin
    x_nxt = x;
    y_nxt = y;
    if (set_valid) begin
      if (set_ok) begin
        x_nxt = set_x[XW-1:0];
        y_nxt = set_y;
      end
    end else if (adv) begin
      if (y == Y_ICON) begin
        x_nxt = x_inc;
      end else if (mode == ADDR_VERT) begin
        if (y == Y_LAST) begin
          y_nxt = '0;
          x_nxt = x_inc;
        end else begin
          y_nxt = y + 1'b1;
        end
      end else begin
        x_nxt = x_inc;
        if (x_last) y_nxt = (y == Y_LAST) ? '0 : y + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (ld) begin
      x <= x_nxt;
      y <= y_nxt;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_valid && !adv) |=> ($stable(x) && $stable(y)));
  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && set_y > Y_ICON) |=> ($stable(x) && $stable(y)));
  assert_icon_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && y == Y_ICON) |=> (y == Y_ICON));
  assert_vert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == ADDR_VERT && y < Y_LAST) |=> (y == $past(y) + 1'b1 && $stable(x)));
  assert_horiz_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == ADDR_HORIZ && y != Y_ICON && x != X_MAX)
    |=> (x == $past(x) + 1'b1 && $stable(y)));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && y == Y_LAST && x == X_MAX) |=> (x == '0 && y == '0));
endmodule

// File: rtl/disp_bank_mask.sv
module disp_bank_mask #(
  parameter int BYTE_W     = 8,
  parameter int FULL_BANKS = 4,
  parameter int PART_BIT   = 0,
  parameter int ICON_BIT   = 4,
  localparam int YW        = $clog2(FULL_BANKS + 2),
  localparam int ROWS      = FULL_BANKS * BYTE_W + 2
) (
  input  logic [YW-1:0]     y,
  input  logic [BYTE_W-1:0] data,
  output logic [ROWS-1:0]   mask,
  output logic [ROWS-1:0]   bits
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r < FULL_BANKS * BYTE_W) begin : g_full
      assign mask[r] = (y == YW'(r / BYTE_W));
      assign bits[r] = data[r % BYTE_W];
    end else if (r == FULL_BANKS * BYTE_W) begin : g_part
      assign mask[r] = (y == YW'(FULL_BANKS));
      assign bits[r] = data[PART_BIT];
    end else begin : g_icon
      assign mask[r] = (y == YW'(FULL_BANKS + 1));
      assign bits[r] = data[ICON_BIT];
    end
  end
endmodule

// File: rtl/disp_col_mem.sv
module disp_col_mem #(
  parameter int NUM_COLS   = 128,
  parameter int BYTE_W     = 8,
  parameter int FULL_BANKS = 4,
  parameter int PART_BIT   = 0,
  parameter int ICON_BIT   = 4,
  localparam int XW        = $clog2(NUM_COLS),
  localparam int YW        = $clog2(FULL_BANKS + 2),
  localparam int ROWS      = FULL_BANKS * BYTE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [XW-1:0]     wx,
  input  logic [ROWS-1:0]   wmask,
  input  logic [ROWS-1:0]   wbits,
  input  logic [XW-1:0]     rx,
  input  logic [YW-1:0]     ry,
  output logic [BYTE_W-1:0] rd_data
);
  localparam logic [YW-1:0] Y_PART = YW'(FULL_BANKS);
  localparam logic [YW-1:0] Y_ICON = YW'(FULL_BANKS + 1);

  logic [ROWS-1:0]   mem [NUM_COLS];
  logic [ROWS-1:0]   col;
  logic [BYTE_W-1:0] rd_nxt;

  always_ff @(posedge clk) begin
    if (we) mem[wx] <= (mem[wx] & ~wmask) | (wbits & wmask);
  end

  assign col = mem[rx];

  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < FULL_BANKS; b++) begin
      if (ry == YW'(b)) rd_nxt = col[b*BYTE_W +: BYTE_W];
    end
    if (ry == Y_PART) rd_nxt[PART_BIT] = col[ROWS-2];
    if (ry == Y_ICON) rd_nxt[ICON_BIT] = col[ROWS-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_nxt;
  end

  assert_part_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ry == Y_PART) |=> ((rd_data & ~(BYTE_W'(1) << PART_BIT)) == '0));
  assert_icon_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ry == Y_ICON) |=> ((rd_data & ~(BYTE_W'(1) << ICON_BIT)) == '0));
  assert_bad_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ry > Y_ICON) |=> (rd_data == '0));
endmodule

// File: rtl/disp_ram_autoinc.sv
module disp_ram_autoinc
  import disp_ram_pkg::*;
#(
  parameter int NUM_COLS   = 128,
  parameter int BYTE_W     = 8,
  parameter int FULL_BANKS = 4,
  parameter int PART_BIT   = 0,
  parameter int ICON_BIT   = 4,
  localparam int XW        = $clog2(NUM_COLS),
  localparam int YW        = $clog2(FULL_BANKS + 2),
  localparam int ROWS      = FULL_BANKS * BYTE_W + 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              set_valid,
  input  logic [XW:0]       set_x,
  input  logic [YW-1:0]     set_y,
  input  logic              mode_valid,
  input  logic              mode_vert,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic [XW-1:0]     rd_x,
  input  logic [YW-1:0]     rd_y,
  output logic [BYTE_W-1:0] rd_data,
  output logic [XW-1:0]     ptr_x,
  output logic [YW-1:0]     ptr_y,
  output logic              vert_mode
);
  logic [1:0]      rst_sync;
  logic            rst_n;
  addr_mode_e      mode_q;
  logic            adv;
  logic [ROWS-1:0] wmask, wbits;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= ADDR_HORIZ;
    else if (mode_valid) mode_q <= addr_mode_e'(mode_vert);
  end
  assign vert_mode = (mode_q == ADDR_VERT);

  assign wr_ready = ~set_valid;
  assign adv      = wr_valid & wr_ready;

  disp_ptr_unit #(.NUM_COLS(NUM_COLS), .FULL_BANKS(FULL_BANKS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_x(set_x), .set_y(set_y),
    .adv(adv), .mode(mode_q), .x(ptr_x), .y(ptr_y)
  );

  disp_bank_mask #(.BYTE_W(BYTE_W), .FULL_BANKS(FULL_BANKS),
                   .PART_BIT(PART_BIT), .ICON_BIT(ICON_BIT)) u_mask (
    .y(ptr_y), .data(wr_data), .mask(wmask), .bits(wbits)
  );

  disp_col_mem #(.NUM_COLS(NUM_COLS), .BYTE_W(BYTE_W), .FULL_BANKS(FULL_BANKS),
                 .PART_BIT(PART_BIT), .ICON_BIT(ICON_BIT)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(adv), .wx(ptr_x), .wmask(wmask), .wbits(wbits),
    .rx(rd_x), .ry(rd_y), .rd_data(rd_data)
  );

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_valid) |=> $stable(vert_mode));
  assert_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && set_y <= YW'(FULL_BANKS + 1) && set_x < (XW+1)'(NUM_COLS))
    |=> (ptr_x == $past(set_x[XW-1:0]) && ptr_y == $past(set_y)));
endmodule

// File: tb/disp_ram_autoinc_bench.sv
`timescale 1ns/100ps
module disp_ram_autoinc_bench;
  localparam int NC = 16;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       set_valid, mode_valid, mode_vert, wr_valid;
  logic [4:0] set_x;
  logic [2:0] set_y, rd_y, ptr_y;
  logic [7:0] wr_data, rd_data;
  logic [3:0] rd_x, ptr_x;
  logic       wr_ready, vert_mode;

  int checks = 0, failures = 0;
  string ptag = "R1", rtag = "R2";
  bit    model_on = 0;

  int        mx = 0, my = 0, mv = 0;
  logic [7:0] mem_m [NC][6];
  bit        wr_m [NC][6];
  logic [7:0] exp_rd = 8'h00;
  bit        exp_known = 1;

  always #2.5 clk = ~clk;

  disp_ram_autoinc #(.NUM_COLS(NC)) u_disp_ram_autoinc (
    .clk(clk), .arst_n(arst_n), .set_valid(set_valid), .set_x(set_x), .set_y(set_y),
    .mode_valid(mode_valid), .mode_vert(mode_vert), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_x(rd_x), .rd_y(rd_y), .rd_data(rd_data),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .vert_mode(vert_mode)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: updated on each rising edge, compared just after it
  always @(posedge clk) begin
    if (model_on) begin
      if (rd_y <= 5) begin
        exp_rd = mem_m[rd_x][rd_y];
        exp_known = wr_m[rd_x][rd_y];
      end else begin
        exp_rd = 8'h00;
        exp_known = 1;
      end
      if (set_valid) begin
        if (set_x < NC && set_y <= 5) begin mx = set_x; my = set_y; end
      end else if (wr_valid) begin
        mem_m[mx][my] = (my < 4) ? wr_data : (my == 4) ? (wr_data & 8'h01) : (wr_data & 8'h10);
        wr_m[mx][my] = 1;
        if (my == 5) mx = (mx + 1) % NC;
        else if (mv != 0) begin
          if (my == 4) begin my = 0; mx = (mx + 1) % NC; end
          else my = my + 1;
        end else begin
          if (mx == NC - 1) begin mx = 0; my = (my == 4) ? 0 : my + 1; end
          else mx = mx + 1;
        end
      end
      if (mode_valid) mv = mode_vert;
      #1;
      chk(ptag, ptr_x, mx);
      chk(ptag, ptr_y, my);
      chk("R9", vert_mode, mv);
      chk("R10", wr_ready, !set_valid);
      if (exp_known) chk(rtag, rd_data, exp_rd);
    end
  end

  task automatic clr();
    set_valid = 0; mode_valid = 0; wr_valid = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); end
  endtask
  task automatic do_set(int x, int y);
    @(negedge clk); clr(); set_valid = 1; set_x = 5'(x); set_y = 3'(y);
  endtask
  task automatic do_mode(int v);
    @(negedge clk); clr(); mode_valid = 1; mode_vert = v[0];
  endtask
  task automatic do_wr(int d);
    @(negedge clk); clr(); wr_valid = 1; wr_data = 8'(d);
  endtask
  task automatic do_rd(int x, int y);
    @(negedge clk); clr(); rd_x = 4'(x); rd_y = 3'(y);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) for (int b = 0; b < 6; b++) begin
      wr_m[c][b] = 0; mem_m[c][b] = 8'h00;
    end
    clr(); set_x = 0; set_y = 0; mode_vert = 0; wr_data = 0; rd_x = 0; rd_y = 0;
    arst_n = 0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1", ptr_x, 0); chk("R1", ptr_y, 0); chk("R1", vert_mode, 0); chk("R1", rd_data, 0);
    arst_n = 1;
    idle(3);
    chk("R1", ptr_x, 0); chk("R1", ptr_y, 0); chk("R1", vert_mode, 0);
    model_on = 1;
    idle(1);
    // R3: horizontal stepping across the row end
    ptag = "R3";
    for (int i = 0; i < 20; i++) do_wr(i * 7 + 3);
    rtag = "R2";
    for (int i = 0; i < 4; i++) do_rd(i, 0);
    do_rd(2, 1);
    // R5 / R6: end of bank 4 in horizontal mode
    ptag = "R5"; rtag = "R6";
    do_set(NC - 2, 4);
    do_wr(8'hFE); do_wr(8'hFF); do_wr(8'h5A);
    do_rd(NC - 2, 4); do_rd(NC - 1, 4); do_rd(0, 0);
    // R2: read of the cell written in the same cycle returns old data
    ptag = "R2"; rtag = "R2";
    do_set(5, 0); idle(1);
    @(negedge clk); clr(); rd_x = 5; rd_y = 0; wr_valid = 1; wr_data = 8'hC3;
    do_rd(5, 0);
    // R9: mode change leaves the pointer alone, R4: vertical stepping
    ptag = "R9";
    do_set(3, 2); do_mode(1); idle(1);
    ptag = "R4";
    for (int i = 0; i < 8; i++) do_wr(8'h80 + i);
    do_rd(3, 2); do_rd(3, 3); do_rd(4, 0);
    ptag = "R5";
    do_set(NC - 1, 3);
    do_wr(8'h11); do_wr(8'h01); do_wr(8'h22);
    // R7: icon bank in both modes
    ptag = "R7"; rtag = "R7";
    do_set(NC - 2, 5);
    for (int i = 0; i < 4; i++) do_wr((i % 2 == 0) ? 8'hFF : 8'hEF);
    do_mode(0);
    do_wr(8'h10); do_wr(8'h00);
    do_rd(NC - 2, 5); do_rd(NC - 1, 5); do_rd(0, 5); do_rd(1, 5);
    // R8: out-of-range requests are ignored
    ptag = "R8";
    do_set(NC, 0); do_set(3, 6); do_set(3, 7); do_set(NC + 3, 2); idle(1);
    // R10: write offered during set-address is not taken
    ptag = "R10"; rtag = "R10";
    @(negedge clk); clr(); set_valid = 1; set_x = 2; set_y = 1; wr_valid = 1; wr_data = 8'h77;
    idle(1);
    do_rd(2, 1); do_rd(2, 1);
    // R11: invalid bank reads
    rtag = "R11";
    do_rd(0, 6); do_rd(1, 7);
    // R2: full sweep
    rtag = "R2";
    for (int c = 0; c < NC; c++) for (int b = 0; b < 6; b++) do_rd(c, b);
    idle(3);
    model_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule